// File: doc/BRIEF.md
# Staged Thermal Alarm Controller

This block takes a stream of digital temperature samples in millidegrees Celsius and places the die in one of four alarm stages, 0 (normal) to 3 (critical). The three stage boundaries shift together under a 2-bit threshold index. A hysteresis band stops the stage from chattering when the temperature sits near a boundary. Each accepted sample can move the stage by at most one step.

Software uses a byte-wide register port. Through it, software reads identification bytes, reads the stage, picks the threshold, enables the monitor, masks the shutdown requests and clears them. A stage change raises a level interrupt at once. The reported stage follows only after a programmable settling delay. Stages 2 and 3 each latch their own shutdown request. A request stays set until software clears it once the temperature has fallen below that stage. Software can also mask each request on its own without losing the latched state.

Top module: `thermal_stage_alarm`

## Requirements
- R1: Reading offset 0x04 returns 0x09 and reading offset 0x05 returns 0x08. Offset 0x42 and unmapped offsets read 0x00. Read data is 0x00 while the read strobe is low.
- R2: After reset, every control bit is zero, the stage and the reported status are 0, and the interrupt and both shutdown requests are low.
- R3: The boundary of stage k (k = 1..3) is 105000 + 5000·thr + 20000·(k−1) millidegrees, where thr is bits [1:0] of offset 0x40. An accepted sample at or above the next stage's boundary plus 2000 raises the stage by one.
- R4: An accepted sample below the current stage's boundary minus 2000 lowers the stage by one. A sample between the two limits leaves the stage unchanged.
- R5: The stage changes by at most one step per sample. Samples arrive only with temp_vld high; without it the temperature input has no effect.
- R6: irq goes high on the clock edge that changes the stage while the monitor is enabled. It stays high until offset 0x08 is read with reg_re high.
- R7: Bits [1:0] of offset 0x08 report the new stage exactly SETTLE_CYC clock edges after the edge that changed the stage. Until then they report the previous stage.
- R8: A shutdown request latches while the stage is at least 2 (sd2_req) or equal to 3 (sd3_req). It stays latched after the stage falls.
- R9: Writing offset 0x42 with bit 6 (stage 2) or bit 7 (stage 3) set clears that latch, but only while the stage is below that level.
- R10: Bit 6 (stage 2) and bit 7 (stage 3) of offset 0x40 mask the matching request output. The latched state is kept, so the request returns when the mask bit is cleared.
- R11: The monitor is enabled when bit 7 of offset 0x46 is set, or when bit 0 is set and hw_en is high. While it is disabled, the stage is forced to 0, samples are ignored and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_en | input | 1 | Hardware enable, honoured when the follow bit is set |
| temp_mc | input | TEMP_W | Temperature sample in millidegrees Celsius |
| temp_vld | input | 1 | Sample strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (a status read clears irq) |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| irq | output | 1 | Stage-change interrupt level |
| sd2_req | output | 1 | Stage-2 shutdown request |
| sd3_req | output | 1 | Stage-3 shutdown request |

## Verification
The bench builds the block with SETTLE_CYC = 4 and keeps the other parameters at their defaults. With this setting, the settling lag is checked edge by edge after every single stage change. That makes it cheap to sweep the temperature in 500-millidegree steps, up and then down, across all four threshold indices. Every rising and falling limit, and the value just beside it, is therefore tried against an arithmetic model. Separate runs cover multi-stage jumps, the shutdown latch, mask and clear sequence, and both enable sources.

// File: rtl/tsa_pkg.sv
// Shared types and register offsets for the staged thermal alarm.
// Assumes a byte-wide register port with 8-bit offsets.
package tsa_pkg;
    localparam int unsigned REG_AW = 8;
    localparam int unsigned REG_DW = 8;

    typedef logic [1:0] stage_t;

    localparam logic [REG_AW-1:0] OFS_ID_A  = 8'h04;
    localparam logic [REG_AW-1:0] OFS_ID_B  = 8'h05;
    localparam logic [REG_AW-1:0] OFS_STAT  = 8'h08;
    localparam logic [REG_AW-1:0] OFS_LIMIT = 8'h40;
    localparam logic [REG_AW-1:0] OFS_CLEAR = 8'h42;
    localparam logic [REG_AW-1:0] OFS_ENA   = 8'h46;

    localparam logic [REG_DW-1:0] ID_A_VAL = 8'h09;
    localparam logic [REG_DW-1:0] ID_B_VAL = 8'h08;

    // Software-held control state
    typedef struct packed {
        logic       mask3;
        logic       mask2;
        logic [1:0] thr;
        logic       force_on;
        logic       follow_hw;
    } ctrl_t;
endpackage

// File: rtl/tsa_regs.sv
// Register file: holds control bits, decodes clear pulses and the status
// read, and muxes read data. Assumes one access per cycle.
module tsa_regs
    import tsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    input  logic              we,
    input  logic              re,
    input  stage_t            status,
    output ctrl_t             ctrl,
    output logic [1:0]        sd_clr,
    output logic              stat_rd,
    output logic [REG_DW-1:0] rdata
);
    logic unused_wbits;
    assign unused_wbits = ^{wdata[5:2], wdata[6:1]};

    // Capture control writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (we) begin
            if (addr == OFS_LIMIT) begin
                ctrl.mask3 <= wdata[7];
                ctrl.mask2 <= wdata[6];
                ctrl.thr   <= wdata[1:0];
            end
            if (addr == OFS_ENA) begin
                ctrl.force_on  <= wdata[7];
                ctrl.follow_hw <= wdata[0];
            end
        end
    end

    // Single-cycle clear strobes, index 0 = stage 2, index 1 = stage 3
    assign sd_clr  = (we && addr == OFS_CLEAR) ? wdata[7:6] : 2'b00;
    assign stat_rd = re && (addr == OFS_STAT);

    // Read data mux
    always_comb begin
        rdata = '0;
        if (re) begin
            case (addr)
                OFS_ID_A:  rdata = ID_A_VAL;
                OFS_ID_B:  rdata = ID_B_VAL;
                OFS_STAT:  rdata = {6'd0, status};
                OFS_LIMIT: rdata = {ctrl.mask3, ctrl.mask2, 4'd0, ctrl.thr};
                OFS_ENA:   rdata = {ctrl.force_on, 6'd0, ctrl.follow_hw};
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tsa_stage.sv
// Stage tracker: compares each accepted sample against threshold-relative
// limits with hysteresis and moves at most one stage per sample.
// Assumes boundary arithmetic fits in 32 bits.
module tsa_stage
    import tsa_pkg::*;
#(
    parameter int unsigned TEMP_W        = 20,
    parameter int unsigned BASE_MC       = 105000,
    parameter int unsigned THR_STEP_MC   = 5000,
    parameter int unsigned STAGE_STEP_MC = 20000,
    parameter int unsigned HYST_MC       = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [TEMP_W-1:0] temp,
    input  logic              vld,
    input  logic [1:0]        thr,
    output stage_t            stage,
    output logic              moved,
    output logic              step
);
    localparam stage_t TOP = 2'd3;

    logic [31:0] lvl_base, rise_lim, fall_lim, temp_w;
    stage_t      stage_d;

    // Next stage from the limits around the current one
    always_comb begin
        lvl_base = 32'(BASE_MC) + 32'(THR_STEP_MC) * 32'(thr);
        rise_lim = lvl_base + 32'(STAGE_STEP_MC) * 32'(stage) + 32'(HYST_MC);
        fall_lim = lvl_base + 32'(STAGE_STEP_MC) * 32'(stage)
                   - 32'(STAGE_STEP_MC) - 32'(HYST_MC);
        temp_w   = 32'(temp);
        stage_d  = stage;
        if (!en) begin
            stage_d = '0;
        end else if (vld) begin
            if (stage != TOP && temp_w >= rise_lim) begin
                stage_d = stage + 2'd1;
            end else if (stage != '0 && temp_w < fall_lim) begin
                stage_d = stage - 2'd1;
            end
        end
    end

    // Stage register
    always_ff @(posedge clk) begin
        if (!rst_n) stage <= '0;
        else        stage <= stage_d;
    end

    assign moved = (stage_d != stage);
    assign step  = moved && en;
endmodule

// File: rtl/tsa_report.sv
// Reporting: raises the interrupt level at once on a stage step and copies
// the stage to the status field after SETTLE_CYC edges. Assumes SETTLE_CYC >= 1.
module tsa_report
    import tsa_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 8000000
) (
    input  logic   clk,
    input  logic   rst_n,
    input  stage_t stage,
    input  logic   moved,
    input  logic   step,
    input  logic   stat_rd,
    output stage_t status,
    output logic   irq
);
    localparam int unsigned CW = $clog2(SETTLE_CYC + 1);

    logic [CW-1:0] wait_cnt;

    // Settling counter, restarted by every stage movement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
            status   <= '0;
        end else if (moved) begin
            wait_cnt <= CW'(SETTLE_CYC);
        end else if (wait_cnt != '0) begin
            wait_cnt <= wait_cnt - CW'(1);
            if (wait_cnt == CW'(1)) status <= stage;
        end
    end

    // Interrupt level: set on a step, cleared by a status read
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (step)    irq <= 1'b1;
        else if (stat_rd) irq <= 1'b0;
    end
endmodule

// File: rtl/tsa_sd_latch.sv
// One shutdown request latch for a given stage level, with clear and mask.
// Assumes clear is a single-cycle strobe.
module tsa_sd_latch
    import tsa_pkg::*;
#(
    parameter int LEVEL = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  stage_t stage,
    input  logic   clr,
    input  logic   mask,
    output logic   lat,
    output logic   req
);
    logic at_level;
    assign at_level = (int'(stage) >= LEVEL);

    // Latch on reaching the level; clear only once below it
    always_ff @(posedge clk) begin
        if (!rst_n)        lat <= 1'b0;
        else if (at_level) lat <= 1'b1;
        else if (clr)      lat <= 1'b0;
    end

    assign req = lat && !mask;
endmodule

// File: rtl/thermal_stage_alarm.sv
// Top: staged thermal alarm with hysteresis, settled status, level interrupt
// and two latched, maskable shutdown requests. Assumes temp_mc is unsigned.
module thermal_stage_alarm
    import tsa_pkg::*;
#(
    parameter int unsigned TEMP_W        = 20,
    parameter int unsigned SETTLE_CYC    = 8000000,
    parameter int unsigned BASE_MC       = 105000,
    parameter int unsigned THR_STEP_MC   = 5000,
    parameter int unsigned STAGE_STEP_MC = 20000,
    parameter int unsigned HYST_MC       = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_en,
    input  logic [TEMP_W-1:0] temp_mc,
    input  logic              temp_vld,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    input  logic              reg_we,
    input  logic              reg_re,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq,
    output logic              sd2_req,
    output logic              sd3_req
);
    localparam int N_SD = 2;

    ctrl_t          ctrl;
    stage_t         stage_q, status_q;
    logic           mon_en, moved, step, stat_rd;
    logic [N_SD-1:0] sd_clr, sd_mask, sd_lat, sd_req;

    assign mon_en  = ctrl.force_on || (ctrl.follow_hw && hw_en);
    assign sd_mask = {ctrl.mask3, ctrl.mask2};

    tsa_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
        .we(reg_we), .re(reg_re), .status(status_q), .ctrl(ctrl),
        .sd_clr(sd_clr), .stat_rd(stat_rd), .rdata(reg_rdata)
    );

    tsa_stage #(
        .TEMP_W(TEMP_W), .BASE_MC(BASE_MC), .THR_STEP_MC(THR_STEP_MC),
        .STAGE_STEP_MC(STAGE_STEP_MC), .HYST_MC(HYST_MC)
    ) u_stage (
        .clk(clk), .rst_n(rst_n), .en(mon_en), .temp(temp_mc), .vld(temp_vld),
        .thr(ctrl.thr), .stage(stage_q), .moved(moved), .step(step)
    );

    tsa_report #(.SETTLE_CYC(SETTLE_CYC)) u_report (
        .clk(clk), .rst_n(rst_n), .stage(stage_q), .moved(moved), .step(step),
        .stat_rd(stat_rd), .status(status_q), .irq(irq)
    );

    // One latch per upper stage: index 0 = stage 2, index 1 = stage 3
    for (genvar g = 0; g < N_SD; g++) begin : g_sd
        tsa_sd_latch #(.LEVEL(g + 2)) u_sd (
            .clk(clk), .rst_n(rst_n), .stage(stage_q), .clr(sd_clr[g]),
            .mask(sd_mask[g]), .lat(sd_lat[g]), .req(sd_req[g])
        );
    end

    assign sd2_req = sd_req[0];
    assign sd3_req = sd_req[1];
endmodule

// File: rtl/tsa_checker.sv
// Temporal checks on the staged thermal alarm, bound into the top module.
module tsa_checker
    import tsa_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input stage_t     stage,
    input stage_t     status,
    input logic       irq,
    input logic       stat_rd,
    input logic [1:0] sd_lat
);
    // R5: at most one step per edge while enabled
    a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en) |-> (({1'b0, stage} == {1'b0, $past(stage)}) ||
                       ({1'b0, stage} == {1'b0, $past(stage)} + 3'd1) ||
                       ({1'b0, stage} + 3'd1 == {1'b0, $past(stage)})));

    // R11: disabled forces stage 0 on the next edge
    a_r11_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (stage == 2'd0));

    // R6: an enabled stage change leaves irq high
    a_r6_irq_on_move: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && stage != $past(stage)) |-> irq);

    // R6: irq holds until a status read
    a_r6_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !stat_rd) |=> irq);

    // R7: status only ever takes the tracked stage value
    a_r7_status_src: assert property (@(posedge clk) disable iff (!rst_n)
        (status != $past(status)) |-> (status == $past(stage)));

    // R8: latches set while the stage is at their level
    a_r8_sd2_set: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stage) >= 2'd2) |-> sd_lat[0]);
    a_r8_sd3_set: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stage) == 2'd3) |-> sd_lat[1]);

    // R9: a latch falls only when the stage was below its level
    a_r9_sd2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_lat[0]) |-> ($past(stage) < 2'd2));
    a_r9_sd3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_lat[1]) |-> ($past(stage) < 2'd3));
endmodule

bind thermal_stage_alarm tsa_checker u_chk (
    .clk(clk), .rst_n(rst_n), .en(mon_en), .stage(stage_q), .status(status_q),
    .irq(irq), .stat_rd(stat_rd), .sd_lat(sd_lat)
);

// File: tb/thermal_stage_alarm_tb_top.sv
`timescale 1ns/1ps
module thermal_stage_alarm_tb_top;
    localparam int SETTLE = 4;
    localparam int TW     = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hw_en = 1'b0;
    logic [TW-1:0] temp_mc = '0;
    logic          temp_vld = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic          reg_we = 1'b0;
    logic          reg_re = 1'b0;
    logic [7:0]    reg_rdata;
    logic          irq, sd2_req, sd3_req;

    int n_chk = 0;
    int n_err = 0;
    int m_stage = 0;
    int m_thr = 0;
    bit m_en = 0;
    int v;

    always #2.5 clk = ~clk;

    thermal_stage_alarm #(.TEMP_W(TW), .SETTLE_CYC(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .temp_mc(temp_mc),
        .temp_vld(temp_vld), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .irq(irq),
        .sd2_req(sd2_req), .sd3_req(sd3_req)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        reg_addr = 8'(a); reg_wdata = 8'(d); reg_we = 1'b1;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        reg_addr = 8'(a); reg_re = 1'b1;
        #1 d = int'(reg_rdata);
        tick();
        reg_re = 1'b0;
    endtask

    function automatic int bnd(input int k);
        return 105000 + 5000 * m_thr + 20000 * (k - 1);
    endfunction

    // Apply one sample, update the model, check irq, lag and status
    task automatic probe(input int t, input string tag);
        int old_s;
        bit mv;
        old_s = m_stage;
        temp_mc = TW'(t); temp_vld = 1'b1;
        tick();
        temp_vld = 1'b0;
        if (m_en) begin
            if (m_stage < 3 && t >= bnd(m_stage + 1) + 2000) m_stage++;
            else if (m_stage > 0 && t < bnd(m_stage) - 2000) m_stage--;
        end
        mv = (m_stage != old_s);
        check({tag, "/R6 irq"}, int'(irq), int'(mv));
        if (mv) begin
            repeat (SETTLE - 1) tick();
            rd(8'h08, v); check("R7 lag", v, old_s);
            rd(8'h08, v); check({tag, "/R7 settled"}, v, m_stage);
            check("R6 irq cleared by read", int'(irq), 0);
        end else begin
            rd(8'h08, v); check({tag, " stage"}, v, m_stage);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got 0 expected 1 (run ended)");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R2 reset state
        check("R2 irq", int'(irq), 0);
        check("R2 sd2", int'(sd2_req), 0);
        check("R2 sd3", int'(sd3_req), 0);
        rd(8'h40, v); check("R2 limit reg", v, 0);
        rd(8'h46, v); check("R2 enable reg", v, 0);
        rd(8'h08, v); check("R2 status", v, 0);
        // R1 identification and empty offsets
        rd(8'h04, v); check("R1 id a", v, 8'h09);
        rd(8'h05, v); check("R1 id b", v, 8'h08);
        rd(8'h42, v); check("R1 clear reg", v, 0);
        rd(8'h10, v); check("R1 unmapped", v, 0);
        reg_addr = 8'h04; #1 check("R1 no strobe", int'(reg_rdata), 0);

        // R11 disabled: hot samples ignored
        for (int i = 0; i < 3; i++) probe(190000, "R11 disabled");

        wr(8'h46, 8'h80); m_en = 1;
        rd(8'h46, v); check("R11 force readback", v, 8'h80);

        // R3 / R4 sweeps over every threshold
        for (int th = 0; th < 4; th++) begin
            wr(8'h40, th); m_thr = th;
            rd(8'h40, v); check("R3 thr readback", v, th);
            for (int t = 100000; t <= 190000; t += 500) probe(t, "R3");
            for (int t = 190000; t >= 100000; t -= 500) probe(t, "R4");
            wr(8'h42, 8'hC0);
        end

        // R5 one step per sample from a large jump
        wr(8'h40, 0); m_thr = 0;
        for (int i = 0; i < 3; i++) probe(190000, "R5 jump");
        check("R5 reached 3", m_stage, 3);
        temp_mc = TW'(100000);
        repeat (6) tick();
        rd(8'h08, v); check("R5 no strobe ignored", v, 3);

        // R8 / R10 / R9 shutdown latches
        check("R8 sd2 at 3", int'(sd2_req), 1);
        check("R8 sd3 at 3", int'(sd3_req), 1);
        wr(8'h40, 8'hC0);
        check("R10 sd2 masked", int'(sd2_req), 0);
        check("R10 sd3 masked", int'(sd3_req), 0);
        wr(8'h40, 8'h00);
        check("R10 sd2 back", int'(sd2_req), 1);
        check("R10 sd3 back", int'(sd3_req), 1);
        wr(8'h42, 8'hC0);
        tick();
        check("R9 sd2 kept in stage", int'(sd2_req), 1);
        check("R9 sd3 kept in stage", int'(sd3_req), 1);
        for (int i = 0; i < 3; i++) probe(100000, "R4 drop");
        check("R8 sd2 held", int'(sd2_req), 1);
        check("R8 sd3 held", int'(sd3_req), 1);
        wr(8'h42, 8'h40);
        check("R9 sd2 cleared", int'(sd2_req), 0);
        check("R9 sd3 untouched", int'(sd3_req), 1);
        wr(8'h42, 8'h80);
        check("R9 sd3 cleared", int'(sd3_req), 0);

        // R11 follow hardware enable
        wr(8'h46, 8'h01); hw_en = 1'b0; m_en = 0;
        probe(190000, "R11 hw low");
        hw_en = 1'b1; m_en = 1;
        probe(190000, "R11 hw high");
        check("R11 stage 1", m_stage, 1);
        hw_en = 1'b0; m_en = 0; m_stage = 0;
        tick();
        check("R11 no irq on disable", int'(irq), 0);
        repeat (SETTLE + 1) tick();
        rd(8'h08, v); check("R11 status zero", v, 0);
        check("R11 irq still low", int'(irq), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule